// File: doc/BRIEF.md
# Maskable Interrupt Vector Controller

This block collects single-cycle event pulses from a line framer and folds them into eight interrupt categories. Each source has its own enable bit. Each category owns one bit of an 8-bit interrupt vector. When any enabled source fires, its category bit sets and the block asserts an output enable, `irq_oe`. That enable drives a shared, active-low interrupt line to its low level; while it is deasserted the line is released. Software reads the vector over a small register bus, and the read clears the vector. Software can also acknowledge by flipping a toggle bit in a control register.

Alongside the vector, the block keeps a sticky alarm latch. Each selected alarm input sets its bit, and the bit stays set until software reads the latch. This lets short, sporadic alarms be seen long after they have gone away.

The register bus is single-cycle. Software drives `addr` together with a `rd` or `wr` strobe. Read data is registered and appears in `rdata` one clock later. A read and a write are never issued in the same cycle.

Top module: `ivc_top`

## Requirements
- R1: After reset, `irq_oe` is 0 and the vector, the alarm latch, every enable word and the control toggle read 0. The alarm select register reads all ones.
- R2: Event input `evt_i[i]` belongs to category `i / 8`, and its enable is bit `i % 8` of the enable word at address `i / 8` (addresses 0x0 to 0x7). When that enable bit is 1, a pulse sets vector bit `i / 8` at the next clock edge.
- R3: A pulse whose enable bit is 0 sets no vector bit and does not raise `irq_oe`.
- R4: `irq_oe` is 1 in exactly those cycles in which at least one vector bit is set. Vector bits from several categories accumulate until they are cleared.
- R5: A read of address 0x9 returns the vector in `rdata` bits [7:0] one cycle later. The same clock edge clears the vector, so `irq_oe` falls unless a new enabled event arrived in that cycle.
- R6: An enabled event that arrives in the same cycle as a vector read or an acknowledge is not lost. It appears in the vector after the clear, and the read in progress does not return it.
- R7: A write to address 0x8 whose bit 0 differs from the stored toggle bit stores the new bit and clears the vector. A write of the same value leaves the vector unchanged.
- R8: The enable words (0x0 to 0x7), the control register (0x8, toggle in bit 0, other bits read 0) and the alarm select register (0xB) read back the last value written.
- R9: Alarm latch bit j (read at address 0xA) sets when `alarm_i[j]` is 1 and alarm select bit j is 1. The bit stays set until the latch is read. The read returns the value held before the clear.
- R10: An alarm whose select bit is 0 does not set its latch bit.
- R11: Writes to addresses 0x9 and 0xA change neither the vector nor the latch. Reads of addresses 0xC to 0xF return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 64 | Event pulses, eight per category |
| alarm_i | input | 8 | Alarm condition inputs for the sticky latch |
| addr | input | 4 | Register address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid the cycle after `rd` |
| irq_oe | output | 1 | 1 = drive the interrupt line low, 0 = release it |

## Verification
An enabled event pulse shows in `irq_oe` right after the next rising edge. Read data and the read-triggered clear of the vector or latch both take effect at the edge that ends the read cycle. An acknowledge write clears the vector at the edge that ends the write cycle. The bench drives every input at the falling edge and holds it for one full cycle. It samples outputs at the following falling edge, which is half a cycle after the edge where each result is due. The collision case places the event pulse and the read strobe in the same driven cycle, so both land on one edge.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int ADDR_W = 4;
  typedef logic [ADDR_W-1:0] addr_t;
  localparam addr_t A_CTRL = 4'h8;
  localparam addr_t A_VEC  = 4'h9;
  localparam addr_t A_ALM  = 4'hA;
  localparam addr_t A_SEL  = 4'hB;
endpackage

// File: rtl/ivc_regs.sv
module ivc_regs #(
  parameter int NUM_CAT = 8,
  parameter int DATA_W  = 8,
  parameter int ALARM_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  ivc_pkg::addr_t              addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NUM_CAT*DATA_W-1:0]   mask_flat,
  output logic                        ctrl_tog,
  output logic [ALARM_W-1:0]          alm_sel,
  output logic                        ack
);
  import ivc_pkg::*;

  // enable words, one per category
  for (genvar k = 0; k < NUM_CAT; k++) begin : g_mask
    logic [DATA_W-1:0] m_d, m_q;
    logic              m_en;
    always_comb begin
      m_en = wr && (addr == ADDR_W'(k));
      m_d  = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    m_q <= '0;
      else if (m_en) m_q <= m_d;
    end
    assign mask_flat[k*DATA_W +: DATA_W] = m_q;
  end

  logic               tog_q, tog_d, tog_en;
  logic [ALARM_W-1:0] sel_q, sel_d;
  logic               sel_en;

  always_comb begin
    tog_en = wr && (addr == A_CTRL);
    tog_d  = wdata[0];
    ack    = tog_en && (wdata[0] != tog_q);
    sel_en = wr && (addr == A_SEL);
    sel_d  = wdata[ALARM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (tog_en) tog_q <= tog_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '1;
    else if (sel_en) sel_q <= sel_d;
  end

  assign ctrl_tog = tog_q;
  assign alm_sel  = sel_q;
endmodule

// File: rtl/ivc_vector.sv
module ivc_vector #(
  parameter int NUM_CAT = 8,
  parameter int DATA_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CAT*DATA_W-1:0] evt,
  input  logic [NUM_CAT*DATA_W-1:0] mask_flat,
  input  logic                      clr,
  output logic [NUM_CAT-1:0]        vec
);
  for (genvar k = 0; k < NUM_CAT; k++) begin : g_cat
    logic hit, v_d, v_q;
    always_comb begin
      hit = |(evt[k*DATA_W +: DATA_W] & mask_flat[k*DATA_W +: DATA_W]);
      // an event in the clearing cycle survives the clear
      v_d = clr ? hit : (v_q | hit);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end
    assign vec[k] = v_q;
  end
endmodule

// File: rtl/ivc_alarm_latch.sv
module ivc_alarm_latch #(
  parameter int ALARM_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ALARM_W-1:0] alarm,
  input  logic [ALARM_W-1:0] sel,
  input  logic               clr,
  output logic [ALARM_W-1:0] lat
);
  logic [ALARM_W-1:0] lat_d, lat_q;

  always_comb begin
    lat_d = (clr ? '0 : lat_q) | (alarm & sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  assign lat = lat_q;
endmodule

// File: rtl/ivc_top.sv
module ivc_top #(
  parameter int NUM_CAT = 8,
  parameter int DATA_W  = 8,
  parameter int ALARM_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CAT*DATA_W-1:0]   evt_i,
  input  logic [ALARM_W-1:0]          alarm_i,
  input  logic [ivc_pkg::ADDR_W-1:0]  addr,
  input  logic                        rd,
  input  logic                        wr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output logic                        irq_oe
);
  import ivc_pkg::*;

  logic [NUM_CAT*DATA_W-1:0] mask_flat;
  logic                      ctrl_tog;
  logic [ALARM_W-1:0]        alm_sel;
  logic                      ack;
  logic [NUM_CAT-1:0]        vec_q;
  logic [ALARM_W-1:0]        alm_q;
  logic                      vec_clr, alm_clr;
  logic [DATA_W-1:0]         rd_mux, rdata_q;

  ivc_regs #(.NUM_CAT(NUM_CAT), .DATA_W(DATA_W), .ALARM_W(ALARM_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
    .mask_flat(mask_flat), .ctrl_tog(ctrl_tog), .alm_sel(alm_sel), .ack(ack)
  );

  assign vec_clr = (rd && (addr == A_VEC)) || ack;
  assign alm_clr = rd && (addr == A_ALM);

  ivc_vector #(.NUM_CAT(NUM_CAT), .DATA_W(DATA_W)) u_vec (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .mask_flat(mask_flat),
    .clr(vec_clr), .vec(vec_q)
  );

  ivc_alarm_latch #(.ALARM_W(ALARM_W)) u_alm (
    .clk(clk), .rst_n(rst_n), .alarm(alarm_i), .sel(alm_sel),
    .clr(alm_clr), .lat(alm_q)
  );

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_CAT; k++)
      if (addr == ADDR_W'(k)) rd_mux = mask_flat[k*DATA_W +: DATA_W];
    case (addr)
      A_CTRL:  rd_mux[0] = ctrl_tog;
      A_VEC:   rd_mux[NUM_CAT-1:0] = vec_q;
      A_ALM:   rd_mux[ALARM_W-1:0] = alm_q;
      A_SEL:   rd_mux[ALARM_W-1:0] = alm_sel;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign rdata  = rdata_q;
  assign irq_oe = |vec_q;
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
  parameter int NUM_CAT = 8,
  parameter int DATA_W  = 8,
  parameter int ALARM_W = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_CAT*DATA_W-1:0]  evt_i,
  input logic [NUM_CAT*DATA_W-1:0]  mask_flat,
  input logic [ivc_pkg::ADDR_W-1:0] addr,
  input logic                       rd,
  input logic                       wr,
  input logic                       wbit,
  input logic                       ctrl_tog,
  input logic [ALARM_W-1:0]         alm_q,
  input logic                       irq_oe
);
  import ivc_pkg::*;

  logic hit_any, vec_rd, ack_wr, alm_rd;
  assign hit_any = |(evt_i & mask_flat);
  assign vec_rd  = rd && (addr == A_VEC);
  assign ack_wr  = wr && (addr == A_CTRL) && (wbit != ctrl_tog);
  assign alm_rd  = rd && (addr == A_ALM);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!irq_oe && (alm_q == '0));
    end
  end

  p_enabled_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |=> irq_oe);

  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_oe && !hit_any) |=> !irq_oe);

  p_irq_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_oe && !vec_rd && !ack_wr) |=> irq_oe);

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && !hit_any) |=> !irq_oe);

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !hit_any) |=> !irq_oe);

  p_latch_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !alm_rd |=> ((alm_q & $past(alm_q)) == $past(alm_q)));
endmodule

bind ivc_top ivc_checker #(.NUM_CAT(NUM_CAT), .DATA_W(DATA_W), .ALARM_W(ALARM_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .mask_flat(mask_flat),
  .addr(addr), .rd(rd), .wr(wr), .wbit(wdata[0]), .ctrl_tog(ctrl_tog),
  .alm_q(alm_q), .irq_oe(irq_oe)
);

// File: tb/test_ivc_top.sv
module test_ivc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] evt_i;
  logic [7:0]  alarm_i;
  logic [3:0]  addr;
  logic        rd, wr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        irq_oe;
  int          errors = 0;
  int          checks = 0;

  always #2 clk = ~clk;  // 250 MHz

  ivc_top i_ivc_top (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .alarm_i(alarm_i),
    .addr(addr), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata), .irq_oe(irq_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs change at negedge, results sampled at the next negedge
  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic pulse_evt(input int idx);
    evt_i = '0; evt_i[idx] = 1'b1;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic pulse_alarm(input logic [7:0] a);
    alarm_i = a;
    @(negedge clk);
    alarm_i = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq_oe", {7'b0, irq_oe}, 8'h00);
    bus_read(4'h9, d); check("R1 vector", d, 8'h00);
    bus_read(4'hA, d); check("R1 alarm latch", d, 8'h00);
    bus_read(4'h0, d); check("R1 enable word 0", d, 8'h00);
    bus_read(4'h8, d); check("R1 control", d, 8'h00);
    bus_read(4'hB, d); check("R1 alarm select", d, 8'hFF);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    bus_write(4'h3, 8'h10);
    bus_write(4'h7, 8'h80);
    bus_write(4'h0, 8'h01);
    bus_write(4'h2, 8'h01);
    bus_write(4'h5, 8'h40);
    bus_read(4'h3, d); check("R8 enable word 3", d, 8'h10);
    bus_read(4'h7, d); check("R8 enable word 7", d, 8'h80);
    bus_read(4'h5, d); check("R8 enable word 5", d, 8'h40);
  endtask

  task automatic t_event();
    logic [7:0] d;
    pulse_evt(28);  // category 3, bit 4
    check("R2 irq after enabled event", {7'b0, irq_oe}, 8'h01);
    repeat (3) @(negedge clk);
    check("R4 irq held", {7'b0, irq_oe}, 8'h01);
    bus_read(4'h9, d); check("R2 vector category 3", d, 8'h08);
    check("R5 irq released after read", {7'b0, irq_oe}, 8'h00);
    bus_read(4'h9, d); check("R5 vector cleared", d, 8'h00);
  endtask

  task automatic t_masked();
    logic [7:0] d;
    pulse_evt(24);  // category 3, bit 0, disabled
    check("R3 masked event no irq", {7'b0, irq_oe}, 8'h00);
    pulse_evt(63 - 1);  // category 7, bit 6, disabled
    bus_read(4'h9, d); check("R3 masked vector", d, 8'h00);
  endtask

  task automatic t_accumulate();
    logic [7:0] d;
    pulse_evt(63);
    pulse_evt(0);
    check("R4 irq two categories", {7'b0, irq_oe}, 8'h01);
    bus_read(4'h9, d); check("R4 accumulated vector", d, 8'h81);
    check("R4 irq low when empty", {7'b0, irq_oe}, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    pulse_evt(16);  // category 2
    addr = 4'h9; rd = 1'b1; evt_i = '0; evt_i[46] = 1'b1;  // category 5, same cycle
    @(negedge clk);
    rd = 1'b0; evt_i = '0;
    check("R6 read excludes colliding event", rdata, 8'h04);
    check("R6 irq kept by colliding event", {7'b0, irq_oe}, 8'h01);
    bus_read(4'h9, d); check("R6 colliding event kept", d, 8'h20);
  endtask

  task automatic t_ack();
    logic [7:0] d;
    pulse_evt(17);  // category 2 bit 1, disabled
    pulse_evt(16);
    bus_write(4'h8, 8'h01);
    check("R7 toggle acknowledges", {7'b0, irq_oe}, 8'h00);
    bus_read(4'h8, d); check("R8 control readback", d, 8'h01);
    pulse_evt(16);
    bus_write(4'h8, 8'h01);
    check("R7 same value no ack", {7'b0, irq_oe}, 8'h01);
    addr = 4'h8; wdata = 8'h00; wr = 1'b1; evt_i = '0; evt_i[0] = 1'b1;
    @(negedge clk);
    wr = 1'b0; evt_i = '0;
    bus_read(4'h9, d); check("R6 event kept over ack", d, 8'h01);
  endtask

  task automatic t_alarm();
    logic [7:0] d;
    pulse_alarm(8'h08);
    repeat (4) @(negedge clk);
    bus_read(4'hA, d); check("R9 sticky alarm", d, 8'h08);
    bus_read(4'hA, d); check("R9 latch cleared by read", d, 8'h00);
    pulse_alarm(8'h01);
    @(negedge clk);
    pulse_alarm(8'h04);
    bus_read(4'hA, d); check("R9 alarms accumulate", d, 8'h05);
    bus_write(4'hB, 8'hFE);
    bus_read(4'hB, d); check("R8 select readback", d, 8'hFE);
    pulse_alarm(8'h01);
    bus_read(4'hA, d); check("R10 unselected alarm ignored", d, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    pulse_evt(28);
    bus_write(4'h9, 8'h00);
    check("R11 vector write ignored", {7'b0, irq_oe}, 8'h01);
    bus_read(4'h9, d); check("R11 vector intact", d, 8'h08);
    pulse_alarm(8'h02);
    bus_write(4'hA, 8'h00);
    bus_read(4'hA, d); check("R11 latch write ignored", d, 8'h02);
    bus_write(4'h9, 8'hFF);
    bus_read(4'h9, d); check("R11 vector not set by write", d, 8'h00);
    bus_read(4'hC, d); check("R11 unmapped 0xC", d, 8'h00);
    bus_read(4'hF, d); check("R11 unmapped 0xF", d, 8'h00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_i = '0; alarm_i = '0; addr = '0; rd = 1'b0; wr = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_event();
    t_masked();
    t_accumulate();
    t_collision();
    t_ack();
    t_alarm();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule